// File: doc/BRIEF.md
# Masked Pattern-Match Trace Monitor

The block watches a 64-bit stream of trace words. Each word comes with a valid flag. Two comparators look at every accepted word, and each has its own value and care-mask. The first comparator decides whether a timestamp is requested for that word. The second raises a one-cycle trigger pulse. A third path forwards the word with a strobe. In continuous mode every accepted word is forwarded. In change-only mode a word is forwarded only when it differs from the word accepted before it.

Software programs the block through a simple word-wide register port. Writes take effect at the clock edge. Reads are combinational from the address. The port holds:
- a control word with the enable bit and the collection-mode bit;
- a timestamp-request enable;
- two 32-bit halves for each of the four pattern and mask groups.

All outputs are registered one cycle behind the input word they describe.

Top module: `trace_patt_mon`

## Requirements
- R1: After reset, every register reads as zero and `out_valid`, `trig` and `ts_req` are low.
- R2: The register map is as follows, and all of these registers can be written and read back:
  - 0xA00: control. Bit 0 is enable. Bit 1 is mode, where 0 means continuous and 1 means change-only.
  - 0xA04: timestamp-request enable, at bit 0.
  - 0xA08 and 0xA0C: timestamp pattern.
  - 0xA10 and 0xA14: timestamp mask.
  - 0xA18 and 0xA1C: trigger pattern.
  - 0xA20 and 0xA24: trigger mask.

  Any other address reads as zero, and a write to it changes no register.
- R3: Bit n of a mask governs bit n of its pattern. A 1 means the bit is compared, and a 0 means the bit is ignored. An all-zero mask matches every word. The lower address of each pair holds data bits 31:0, and the higher address holds bits 63:32.
- R4: `trig` is high for exactly the one cycle after an accepted word that matches the trigger pattern under the trigger mask. The timestamp enable does not affect it.
- R5: `ts_req` is high for the one cycle after an accepted word only when the timestamp-request enable is set and the word matches the timestamp pattern under the timestamp mask.
- R6: While the enable bit is clear, valid input words produce no `out_valid`, `trig` or `ts_req`.
- R7: In continuous mode, every accepted word produces `out_valid` one cycle later, with `out_data` equal to that word.
- R8: In change-only mode, a word is forwarded only if it differs from the previously accepted word. The first word accepted after the enable bit is set is always forwarded.
- R9: A cycle with `in_valid` low produces no output pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Input word valid |
| in_data | input | 64 | Input trace word |
| out_valid | output | 1 | Forwarded-word strobe |
| out_data | output | 64 | Forwarded word |
| trig | output | 1 | Trigger pulse |
| ts_req | output | 1 | Timestamp request pulse |

## Verification
The properties assume that a configuration write never lands in the same cycle as a valid data word. Without that, the comparison would mix the old and new settings. The bench keeps `in_valid` low on every register-access cycle and changes the configuration only between bursts of data. It keeps `in_data` stable over consecutive valid cycles only where it means to exercise the change-only repeat case.

// File: rtl/trace_patt_mon.sv
module trace_patt_mon #(
  parameter int DATA_W = 64,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = 12'hA00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              trig,
  output logic              ts_req
);
  localparam int NW   = DATA_W / REG_W;
  localparam int NGRP = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = BASE;
  localparam logic [ADDR_W-1:0] A_TSEN = BASE + ADDR_W'(4);

  function automatic logic [ADDR_W-1:0] grp_addr(int g, int i);
    return BASE + ADDR_W'(8 + 4 * (g * NW + i));
  endfunction

  // groups: 0 ts pattern, 1 ts mask, 2 trig pattern, 3 trig mask
  logic [DATA_W-1:0] pat_q [NGRP];
  logic en_q, mode_q, tsen_q;
  logic have_prev;
  logic [DATA_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      tsen_q <= 1'b0;
      for (int g = 0; g < NGRP; g++) pat_q[g] <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_CTRL) {mode_q, en_q} <= reg_wdata[1:0];
      if (reg_addr == A_TSEN) tsen_q <= reg_wdata[0];
      for (int g = 0; g < NGRP; g++)
        for (int i = 0; i < NW; i++)
          if (reg_addr == grp_addr(g, i)) pat_q[g][i*REG_W +: REG_W] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) reg_rdata = {{(REG_W-2){1'b0}}, mode_q, en_q};
    if (reg_addr == A_TSEN) reg_rdata = {{(REG_W-1){1'b0}}, tsen_q};
    for (int g = 0; g < NGRP; g++)
      for (int i = 0; i < NW; i++)
        if (reg_addr == grp_addr(g, i)) reg_rdata = pat_q[g][i*REG_W +: REG_W];
  end

  wire take    = in_valid & en_q;
  wire ts_hit  = (((in_data ^ pat_q[0]) & pat_q[1]) == '0);
  wire tg_hit  = (((in_data ^ pat_q[2]) & pat_q[3]) == '0);
  wire changed = !have_prev || (in_data != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      trig      <= 1'b0;
      ts_req    <= 1'b0;
      have_prev <= 1'b0;
      prev_q    <= '0;
    end else begin
      trig      <= take & tg_hit;
      ts_req    <= take & tsen_q & ts_hit;
      out_valid <= take & (!mode_q | changed);
      have_prev <= en_q & (have_prev | in_valid);
      if (take) begin
        out_data <= in_data;
        prev_q   <= in_data;
      end
    end
  end
endmodule

module trace_patt_mon_chk #(parameter int DATA_W = 64) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              en,
  input logic              mode,
  input logic              tsen,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              trig,
  input logic              ts_req
);
  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_valid && !trig && !ts_req);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !trig && !ts_req);
  // R5
  ts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tsen |=> !ts_req);
  // R7
  cont_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && en && !mode) |=> out_valid && out_data == $past(in_data));
  // R8
  repeat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && en && mode) ##1 (in_valid && en && mode && $stable(in_data)) |=> !out_valid);
endmodule

bind trace_patt_mon trace_patt_mon_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .en(en_q), .mode(mode_q), .tsen(tsen_q), .out_valid(out_valid),
  .out_data(out_data), .trig(trig), .ts_req(ts_req));

// File: tb/test_trace_patt_mon.sv
module test_trace_patt_mon;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic in_valid = 0;
  logic [63:0] in_data = 0, out_data;
  logic out_valid, trig, ts_req;

  always #10 clk = ~clk;

  trace_patt_mon i_trace_patt_mon (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .trig(trig), .ts_req(ts_req));

  typedef struct { bit ov; bit tg; bit ts; logic [63:0] d; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int errors = 0, checks = 0;
  bit started = 0, done = 0;

  bit m_en, m_mode, m_tsen, m_have;
  logic [63:0] m_pat[4];
  logic [63:0] m_prev;

  function automatic bit hit(logic [63:0] d, logic [63:0] p, logic [63:0] m);
    for (int b = 0; b < 64; b++) if (m[b] && d[b] != p[b]) return 0;
    return 1;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) if (started && exp_q.size() > 0) begin
    exp_t e; string t;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    #10;
    check(t, "out_valid", 64'(out_valid), 64'(e.ov));
    check(t, "trig", 64'(trig), 64'(e.tg));
    check(t, "ts_req", 64'(ts_req), 64'(e.ts));
    if (e.ov) check(t, "out_data", out_data, e.d);
  end

  task automatic push(bit ov, bit tg, bit ts, logic [63:0] d, string tag);
    exp_t e;
    e.ov = ov; e.tg = tg; e.ts = ts; e.d = d;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] v);
    @(posedge clk); #2;
    reg_we = 1; reg_addr = a; reg_wdata = v; in_valid = 0;
    if (a == 12'hA00) begin
      m_en = v[0]; m_mode = v[1];
      if (!v[0]) m_have = 0;
    end else if (a == 12'hA04) m_tsen = v[0];
    else if (a >= 12'hA08 && a <= 12'hA24 && a[1:0] == 0) begin
      int g, i;
      g = int'((a - 12'hA08) >> 3); i = int'(((a - 12'hA08) >> 2) & 1);
      m_pat[g][i*32 +: 32] = v;
    end
    push(0, 0, 0, '0, "R9");
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] expv, string tag);
    @(posedge clk); #2;
    reg_we = 0; reg_addr = a; in_valid = 0;
    #2;
    check(tag, "reg_rdata", 64'(reg_rdata), 64'(expv));
    push(0, 0, 0, '0, "R9");
  endtask

  task automatic send(bit v, logic [63:0] d, string tag);
    bit ov, tg, ts;
    @(posedge clk); #2;
    reg_we = 0; in_valid = v; in_data = d;
    ov = 0; tg = 0; ts = 0;
    if (v && m_en) begin
      tg = hit(d, m_pat[2], m_pat[3]);
      ts = m_tsen && hit(d, m_pat[0], m_pat[1]);
      ov = !m_mode || !m_have || d != m_prev;
      m_have = 1; m_prev = d;
    end
    push(ov, tg, ts, d, tag);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_en = 0; m_mode = 0; m_tsen = 0; m_have = 0; m_prev = 0;
    for (int g = 0; g < 4; g++) m_pat[g] = '0;
    #45;
    // R1 reset state
    check("R1", "out_valid", 64'(out_valid), 0);
    check("R1", "trig", 64'(trig), 0);
    check("R1", "ts_req", 64'(ts_req), 0);
    rst_n = 1;
    started = 1;
    rd(12'hA00, 0, "R1");
    rd(12'hA1C, 0, "R1");
    rd(12'hA04, 0, "R1");

    // R2 register map readback, unmapped address ignored
    for (int k = 0; k < 8; k++) wr(12'(12'hA08 + 4 * k), 32'h1111_0000 + 32'(k * 32'h0101));
    for (int k = 0; k < 8; k++) rd(12'(12'hA08 + 4 * k), 32'h1111_0000 + 32'(k * 32'h0101), "R2");
    wr(12'hA28, 32'hFFFF_FFFF);
    rd(12'hA28, 0, "R2");
    rd(12'hA24, 32'h1111_0707, "R2");
    wr(12'hA00, 32'h3);
    rd(12'hA00, 32'h3, "R2");
    wr(12'hA04, 32'h1);
    rd(12'hA04, 32'h1, "R2");

    // R6 disabled: nothing emitted
    wr(12'hA00, 0);
    wr(12'hA04, 0);
    for (int k = 0; k < 8; k++) wr(12'(12'hA08 + 4 * k), 0);
    send(1, 64'h1234, "R6");
    send(1, 64'h0, "R6");

    // R3 all-zero masks match all; R7 continuous mode
    wr(12'hA00, 32'h1);
    send(1, 64'hAAAA_5555_0000_FFFF, "R7");
    send(0, 64'h0, "R9");
    send(1, 64'hAAAA_5555_0000_FFFF, "R7");
    send(1, 64'h0123_4567_89AB_CDEF, "R3");

    // R3/R4 partial masks, word halves
    wr(12'hA18, 32'h0000_005A);
    wr(12'hA20, 32'h0000_00FF);
    wr(12'hA1C, 32'hDEAD_0000);
    wr(12'hA24, 32'hFFFF_0000);
    send(1, 64'hDEAD_1234_9999_995A, "R4");
    send(1, 64'hDEAD_1234_9999_995B, "R3");
    send(1, 64'hDEAE_1234_9999_995A, "R3");
    send(1, 64'hDEAD_FFFF_0000_005A, "R4");

    // R5 timestamp request
    wr(12'hA08, 32'h0000_0F00);
    wr(12'hA10, 32'h0000_0F00);
    send(1, 64'h0000_0000_0000_0F00, "R5");
    wr(12'hA04, 32'h1);
    send(1, 64'h0000_0000_0000_0F00, "R5");
    send(1, 64'h0000_0000_0000_0E00, "R5");
    send(1, 64'hDEAD_0000_0000_0F5A, "R5");

    // R8 change-only mode
    wr(12'hA00, 32'h3);
    send(1, 64'hA, "R8");
    send(1, 64'hA, "R8");
    send(1, 64'hB, "R8");
    send(0, 64'hC, "R9");
    send(1, 64'hB, "R8");
    send(1, 64'hA, "R8");
    wr(12'hA00, 32'h2);
    send(1, 64'hA, "R6");
    wr(12'hA00, 32'h3);
    send(1, 64'hA, "R8");
    send(1, 64'hA, "R8");

    for (int k = 0; k < 3; k++) send(0, 64'h0, "R9");
    @(posedge clk); @(posedge clk); #15;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule